// File: doc/BRIEF.md
# Lockable Power and Pin-Mux Control Registers

A small register block on a 16-bit peripheral bus with three mapped registers. The first is a read-only identification half-word. The second is a power-control register with a 2-bit regulator-standby field. Bit 0 of that field picks standby mode. Bit 1 locks the field against later writes, and only reset clears the lock. The third register holds one select bit per shared pin. Each bit steers its pin to a PWM output or to an internal clock output.

Every shared pin goes through a three-level priority. When GPIO owns the pin, the GPIO value wins. Otherwise the select bit chooses between PWM and the clock source. Writes take effect on a clock edge. Reads are combinational from the address.

Top module: `lpm_ctrl_regs`

## Requirements
- R1: Offset 8 reads the standby field in bits 1..0; bits 15..2 always read 0 whatever was written.
- R2: Standby field bit 0 selects the mode (0 normal, 1 standby); `reg_stby_o` is high exactly when bit 0 is 1.
- R3: While bit 1 (lock) of the standby field is 1, writes to offset 8 leave both bits unchanged.
- R4: Writing a value with bit 1 set to an unlocked field stores both bits in that same write, i.e. 10 gives locked normal and 11 gives locked standby.
- R5: Only reset clears the lock; after reset the standby field reads 00.
- R6: Offset 7 always reads 0x401D; writes to it have no effect.
- R7: A pin whose GPIO peripheral-enable bit is 0 outputs its GPIO value, whatever the select register holds.
- R8: A pin whose peripheral-enable bit is 1 outputs its PWM input when its select bit (offset 9, bit n for pin n) is 1, and its clock-source input when it is 0; offset 9 bits 15..4 read 0.
- R9: After reset the select register reads 0x000F, so every pin in peripheral mode carries PWM.
- R10: A register is written on a rising clock edge only when `cs_i` and `we_i` are both high; otherwise no register changes.
- R11: `rdata_o` follows `addr_i` combinationally; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select |
| we_i | input | 1 | Write enable |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| gpio_pe_i | input | 4 | Per-pin peripheral enable (0 = GPIO owns pin) |
| gpio_val_i | input | 4 | GPIO output values |
| pwm_i | input | 4 | PWM outputs |
| clk_src_i | input | 4 | Internal clock outputs |
| pin_o | output | 4 | Muxed pin outputs |
| reg_stby_o | output | 1 | Regulator standby request |

## Verification
The standby field gets directed sequences. These write each of the four codes from the unlocked state, then attempt writes after locking, then reset. Together they separate a lock that is honoured from one that merely holds the mode, and a lock that sets at once from one that sets a write late. Random bus traffic mixes writes with `cs_i` or `we_i` low, writes to the ID and unmapped offsets, and random data with upper bits set. This exposes writes that leak or masks that are missing. Random pin inputs, covering every combination of peripheral enable, select bit, GPIO, PWM and clock value, separate the GPIO-first priority from the select-first one and PWM from the clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned N_PINS = 4;
  localparam int unsigned STBY_W = 2;

  localparam logic [ADDR_W-1:0] OFF_ID  = 4'd7;
  localparam logic [ADDR_W-1:0] OFF_PWR = 4'd8;
  localparam logic [ADDR_W-1:0] OFF_SEL = 4'd9;

  localparam logic [DATA_W-1:0] ID_VAL = 16'h401D;

  typedef struct packed {
    logic lock;
    logic stby;
  } stby_t;
endpackage

// File: rtl/lpm_pwr_ctrl.sv
module lpm_pwr_ctrl
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [STBY_W-1:0] wdata_i,
  output stby_t             field_o
);
  stby_t field_q;

  // lock is sticky: once set, only reset frees the field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   field_q <= '0;
    else if (wr_i && !field_q.lock) field_q <= stby_t'(wdata_i);
  end

  assign field_o = field_q;
endmodule

// File: rtl/lpm_clk_sel.sv
module lpm_clk_sel #(
  parameter int unsigned N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] sel_o
);
  logic [N_PINS-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '1;
    else if (wr_i) sel_q <= wdata_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/lpm_pin_mux.sv
module lpm_pin_mux #(
  parameter int unsigned N_PINS = 4
) (
  input  logic [N_PINS-1:0] pe_i,
  input  logic [N_PINS-1:0] sel_i,
  input  logic [N_PINS-1:0] gpio_i,
  input  logic [N_PINS-1:0] pwm_i,
  input  logic [N_PINS-1:0] clk_src_i,
  output logic [N_PINS-1:0] pin_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic periph;
    assign periph   = sel_i[g] ? pwm_i[g] : clk_src_i[g];
    assign pin_o[g] = pe_i[g] ? periph : gpio_i[g];
  end
endmodule

// File: rtl/lpm_ctrl_regs.sv
module lpm_ctrl_regs
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] gpio_pe_i,
  input  logic [N_PINS-1:0] gpio_val_i,
  input  logic [N_PINS-1:0] pwm_i,
  input  logic [N_PINS-1:0] clk_src_i,
  output logic [N_PINS-1:0] pin_o,
  output logic              reg_stby_o
);
  logic              wr;
  logic              wr_pwr, wr_sel;
  stby_t             pwr;
  logic [N_PINS-1:0] sel;

  assign wr     = cs_i && we_i;
  assign wr_pwr = wr && (addr_i == OFF_PWR);
  assign wr_sel = wr && (addr_i == OFF_SEL);

  lpm_pwr_ctrl u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_pwr),
    .wdata_i (wdata_i[STBY_W-1:0]),
    .field_o (pwr)
  );

  lpm_clk_sel #(.N_PINS(N_PINS)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel),
    .wdata_i (wdata_i[N_PINS-1:0]),
    .sel_o   (sel)
  );

  lpm_pin_mux #(.N_PINS(N_PINS)) u_mux (
    .pe_i      (gpio_pe_i),
    .sel_i     (sel),
    .gpio_i    (gpio_val_i),
    .pwm_i     (pwm_i),
    .clk_src_i (clk_src_i),
    .pin_o     (pin_o)
  );

  assign reg_stby_o = pwr.stby;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_ID:  rdata_o = ID_VAL;
      OFF_PWR: rdata_o[STBY_W-1:0] = pwr;
      OFF_SEL: rdata_o[N_PINS-1:0] = sel;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl_regs_chk.sv
module lpm_ctrl_regs_chk
  import lpm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_PINS-1:0] gpio_pe_i,
  input logic [N_PINS-1:0] gpio_val_i,
  input logic [N_PINS-1:0] pin_o,
  input logic              reg_stby_o,
  input stby_t             pwr
);
  AST_PWR_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_PWR) |-> (rdata_o[DATA_W-1:STBY_W] == '0)); // R1

  AST_STBY_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_PWR) |-> (rdata_o[0] == reg_stby_o)); // R2

  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr.lock |=> (pwr == $past(pwr))); // R3

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr.lock |=> pwr.lock); // R5

  AST_ID_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_ID) |-> (rdata_o == ID_VAL)); // R6

  AST_GPIO_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((pin_o ^ gpio_val_i) & ~gpio_pe_i) == '0)); // R7

  AST_SEL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_SEL) |-> (rdata_o[DATA_W-1:N_PINS] == '0)); // R8

  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && we_i) |=> (pwr == $past(pwr))); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != OFF_ID && addr_i != OFF_PWR && addr_i != OFF_SEL) |-> (rdata_o == '0)); // R11
endmodule

bind lpm_ctrl_regs lpm_ctrl_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .gpio_pe_i  (gpio_pe_i),
  .gpio_val_i (gpio_val_i),
  .pin_o      (pin_o),
  .reg_stby_o (reg_stby_o),
  .pwr        (pwr)
);

// File: tb/sim_lpm_ctrl_regs.sv
`timescale 1ns/1ps
module sim_lpm_ctrl_regs;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        cs_i = 0, we_i = 0;
  logic [3:0]  addr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] rdata_o;
  logic [3:0]  gpio_pe_i = 0, gpio_val_i = 0, pwm_i = 0, clk_src_i = 0;
  logic [3:0]  pin_o;
  logic        reg_stby_o;

  int n_chk = 0, n_fail = 0;
  logic [1:0] m_pwr;
  logic [3:0] m_sel;

  always #2 clk_i = ~clk_i;

  lpm_ctrl_regs u0 (.*);

  function automatic logic [15:0] exp_rd(logic [3:0] a);
    case (a)
      4'd7:    return 16'h401D;
      4'd8:    return {14'd0, m_pwr};
      4'd9:    return {12'd0, m_sel};
      default: return 16'd0;
    endcase
  endfunction

  function automatic logic [3:0] exp_pins(logic [3:0] pe, logic [3:0] sel,
      logic [3:0] gv, logic [3:0] pw, logic [3:0] ck);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = !pe[i] ? gv[i] : (sel[i] ? pw[i] : ck[i]);
    return r;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    m_pwr = 2'b00;
    m_sel = 4'hF;
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic bus_wr(logic [3:0] a, logic [15:0] d, logic c, logic w);
    @(negedge clk_i);
    cs_i = c; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    if (c && w) begin
      if (a == 4'd8 && !m_pwr[1]) m_pwr = d[1:0];
      if (a == 4'd9) m_sel = d[3:0];
    end
    cs_i = 0; we_i = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp_rd(a));
  endtask

  task automatic stby_chk(string req);
    rd_chk(req, 4'd8);
    chk({req, " stby"}, {15'd0, reg_stby_o}, {15'd0, m_pwr[0]});
  endtask

  task automatic pin_chk(string req, logic [3:0] pe, logic [3:0] gv,
      logic [3:0] pw, logic [3:0] ck);
    gpio_pe_i = pe; gpio_val_i = gv; pwm_i = pw; clk_src_i = ck;
    #1;
    chk(req, {12'd0, pin_o}, {12'd0, exp_pins(pe, m_sel, gv, pw, ck)});
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pwr = 0; m_sel = 4'hF;
    do_reset();
    // reset state
    stby_chk("R5 reset pwr");
    rd_chk("R9 reset sel", 4'd9);
    rd_chk("R6 id", 4'd7);
    pin_chk("R9 reset pwm", 4'hF, 4'h0, 4'hA, 4'h5);

    // mode codes, unlocked
    bus_wr(4'd8, 16'hFFFD, 1, 1); stby_chk("R1 R2 standby upper masked");
    bus_wr(4'd8, 16'h0000, 1, 1); stby_chk("R2 normal");
    bus_wr(4'd8, 16'h0001, 1, 0); stby_chk("R10 we low");
    bus_wr(4'd8, 16'h0001, 0, 1); stby_chk("R10 cs low");
    // lock with standby
    bus_wr(4'd8, 16'h0003, 1, 1); stby_chk("R4 lock 11");
    bus_wr(4'd8, 16'h0000, 1, 1); stby_chk("R3 locked ignores 00");
    bus_wr(4'd8, 16'h0002, 1, 1); stby_chk("R3 locked ignores 10");
    do_reset(); stby_chk("R5 reset clears lock");
    bus_wr(4'd8, 16'h0002, 1, 1); stby_chk("R4 lock 10");
    bus_wr(4'd8, 16'h0001, 1, 1); stby_chk("R3 locked ignores 01");
    do_reset();

    // ID write ignored
    bus_wr(4'd7, 16'h1234, 1, 1); rd_chk("R6 id write ignored", 4'd7);
    stby_chk("R6 id write no side effect");
    // select register
    bus_wr(4'd9, 16'hFFF5, 1, 1); rd_chk("R8 sel upper masked", 4'd9);
    pin_chk("R8 pwm/clk select", 4'hF, 4'h0, 4'hF, 4'h0);
    pin_chk("R8 clk path", 4'hF, 4'h0, 4'h0, 4'hF);
    pin_chk("R7 gpio priority", 4'h0, 4'h9, 4'hF, 4'hF);
    pin_chk("R7 R8 mixed", 4'h6, 4'hF, 4'h0, 4'h0);
    rd_chk("R11 unmapped 0", 4'd0);
    rd_chk("R11 unmapped 15", 4'd15);

    // random traffic
    for (int it = 0; it < 600; it++) begin
      logic [3:0] a;
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) a = 4'd8; else if (k < 6) a = 4'd9; else if (k < 7) a = 4'd7;
      else a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 39) == 0) do_reset();
      bus_wr(a, 16'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0));
      stby_chk("R2 R3 rand pwr");
      rd_chk("R8 R10 rand sel", 4'd9);
      rd_chk("R6 rand id", 4'd7);
      rd_chk("R11 rand addr", 4'($urandom_range(0, 15)));
      pin_chk("R7 R8 rand pins", 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule